// File: doc/BRIEF.md
# Shared Edge-Triggered Interrupt Adapter Logic

This block is the interrupt front end of one expansion adapter whose request line is wired together with the request lines of other adapters. The controller on that line reacts to edges. A device event sets a pending latch. When the adapter is enabled, the latch pulls the shared active-low line low through an output-enable, so the line behaves like an open-collector wired-OR. Software reads a small status word to learn whether this adapter is the one asking for service. Through a control write, software can set or clear the enable bit and clear the pending latch.

An edge-triggered controller sees no new edge while any adapter still holds the line low. To deal with this, the block watches every I/O write for the global rearm address that belongs to its configured interrupt level. A matching write makes the adapter let go of the line for a short, parameterised window. When the window ends, the adapter pulls the line low again if it is still pending. Every adapter that is still pending then produces a fresh falling edge.

Top module: `shared_irq_adapter`

## Requirements
- R1: After reset the enable bit and the pending latch are both 0, `irq_oe_o` is 0, `irq_n_o` is 1, and `status_o` reads 0.
- R2: A `dev_event_i` pulse while the enable bit is 1 sets the pending latch at that clock edge, so `status_o[0]` reads 1 from the next cycle onward.
- R3: A `dev_event_i` pulse while the enable bit is 0 is ignored, and `status_o[0]` stays 0.
- R4: The line is driven (`irq_oe_o`=1, `irq_n_o`=0) exactly when the enable bit is 1, the pending latch is 1 and no release window is active. Otherwise `irq_oe_o`=0 and `irq_n_o`=1.
- R5: A control write with data bit 0 = 0 clears the enable bit (`status_o[1]`). This stops the request but leaves the pending latch as it was.
- R6: A control write with data bit 1 = 1 clears the pending latch. If a device event is accepted in the same cycle, the latch stays set.
- R7: The rearm address for level L is 0x2F0+L for L=3..7, 0x2F2 for L=9, and 0x6F2+(L-10) for L=10..15. Only I/O address bits [10:0] are compared.
- R8: A matching rearm write opens a release window of HOLD_CYC clocks (`status_o[2]`=1), starting on the next cycle. During the window the line is not driven. Afterwards the line is driven again if the latch is still set.
- R9: Levels 0, 1, 2 and 8 never rearm. An I/O write to any address that does not match opens no window.
- R10: A rearm does not change the pending latch or the enable bit.
- R11: A matching rearm during an open window restarts the window at its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | 4 | Configured interrupt level |
| dev_event_i | input | 1 | One-cycle device interrupt event |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 2 | Bit 0: enable value; bit 1: clear pending |
| io_wr_i | input | 1 | I/O write strobe seen on the host bus |
| io_addr_i | input | IO_AW | I/O write address |
| status_o | output | 3 | Bit 0 pending, bit 1 enable, bit 2 release window active |
| irq_n_o | output | 1 | Active-low request value |
| irq_oe_o | output | 1 | Drive enable for the shared request line |

## Verification
The hardest state to reach is a second rearm that lands while a release window is already open. The bench has to hold the pending latch set and time the second I/O write a few cycles into the window. It then counts the full window again from that write. A second hard case is a clear write and an accepted event in the same cycle. The bench drives these in single-cycle overlaps and then sweeps all sixteen level settings, using the matching address and a near-miss address for each.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

   localparam int unsigned DEC_BITS = 11;

   function automatic logic level_ok(input logic [3:0] lvl);
      return (lvl >= 4'd3 && lvl <= 4'd7) || (lvl >= 4'd9);
   endfunction

   function automatic logic [DEC_BITS-1:0] rearm_target(input logic [3:0] lvl);
      logic [DEC_BITS-1:0] t;
      t = '0;
      if (lvl >= 4'd3 && lvl <= 4'd7)
         t = 11'h2F0 + {7'd0, lvl};
      else if (lvl == 4'd9)
         t = 11'h2F2;
      else if (lvl >= 4'd10)
         t = 11'h6F2 + {7'd0, lvl - 4'd10};
      return t;
   endfunction

endpackage

// File: rtl/sirq_rearm_decode.sv
module sirq_rearm_decode
   import sirq_pkg::*;
#(
   parameter int unsigned IO_AW = 16
) (
   input  logic             io_wr_i,
   input  logic [IO_AW-1:0] io_addr_i,
   input  logic [3:0]       level_i,
   output logic             hit_o
);
   localparam logic [IO_AW-1:0] MASK = IO_AW'((64'd1 << DEC_BITS) - 64'd1);

   logic [IO_AW-1:0] want;
   logic             match;

   always_comb begin
      want  = IO_AW'(rearm_target(level_i));
      match = ((io_addr_i & MASK) == want);
      hit_o = io_wr_i && level_ok(level_i) && match;
   end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl #(
   parameter bit SET_OVER_CLEAR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dev_event_i,
   input  logic       reg_wr_i,
   input  logic [1:0] reg_wdata_i,
   output logic       en_o,
   output logic       pend_o
);
   logic set_req, clr_req;

   always_comb begin
      set_req = dev_event_i && en_o;
      clr_req = reg_wr_i && reg_wdata_i[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_o <= 1'b0;
      else if (reg_wr_i)
         en_o <= reg_wdata_i[0];
   end

   generate
      if (SET_OVER_CLEAR) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (!rst_n)       pend_o <= 1'b0;
            else if (set_req) pend_o <= 1'b1;
            else if (clr_req) pend_o <= 1'b0;
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (!rst_n)       pend_o <= 1'b0;
            else if (clr_req) pend_o <= 1'b0;
            else if (set_req) pend_o <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sirq_hold_timer.sv
module sirq_hold_timer #(
   parameter int unsigned HOLD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic active_o
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (start_i)
         cnt <= LOAD;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign active_o = (cnt != '0);
endmodule

// File: rtl/shared_irq_adapter.sv
module shared_irq_adapter #(
   parameter int unsigned IO_AW          = 16,
   parameter int unsigned HOLD_CYC       = 4,
   parameter bit          SET_OVER_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       level_i,
   input  logic             dev_event_i,
   input  logic             reg_wr_i,
   input  logic [1:0]       reg_wdata_i,
   input  logic             io_wr_i,
   input  logic [IO_AW-1:0] io_addr_i,
   output logic [2:0]       status_o,
   output logic             irq_n_o,
   output logic             irq_oe_o
);
   generate
      if (IO_AW < 11) begin : g_bad_aw
         $error("shared_irq_adapter: IO_AW must cover the 11 decoded bits");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("shared_irq_adapter: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic hit, en, pend, hold, drive;

   sirq_rearm_decode #(.IO_AW(IO_AW)) u_dec (
      .io_wr_i  (io_wr_i),
      .io_addr_i(io_addr_i),
      .level_i  (level_i),
      .hit_o    (hit)
   );

   sirq_ctrl #(.SET_OVER_CLEAR(SET_OVER_CLEAR)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .dev_event_i(dev_event_i),
      .reg_wr_i   (reg_wr_i),
      .reg_wdata_i(reg_wdata_i),
      .en_o       (en),
      .pend_o     (pend)
   );

   sirq_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (hit),
      .active_o(hold)
   );

   always_comb begin
      drive    = en && pend && !hold;
      irq_oe_o = drive;
      irq_n_o  = !drive;
      status_o = {hold, en, pend};
   end
endmodule

// File: rtl/shared_irq_adapter_chk.sv
module shared_irq_adapter_chk #(
   parameter int unsigned IO_AW = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       level_i,
   input logic             dev_event_i,
   input logic             reg_wr_i,
   input logic [1:0]       reg_wdata_i,
   input logic             io_wr_i,
   input logic [IO_AW-1:0] io_addr_i,
   input logic [2:0]       status_o,
   input logic             irq_n_o,
   input logic             irq_oe_o
);
   logic lvl_bad, near;
   logic [10:0] a11;

   always_comb begin
      a11     = io_addr_i[10:0];
      lvl_bad = (level_i == 4'd0) || (level_i == 4'd1) || (level_i == 4'd2) || (level_i == 4'd8);
      case (level_i)
         4'd9:    near = (a11 == 11'h2F2);
         4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15:
                  near = (a11 == (11'h6E8 + {7'd0, level_i}));
         default: near = !lvl_bad && (a11 == (11'h2F0 + {7'd0, level_i}));
      endcase
   end

   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!irq_oe_o && irq_n_o && status_o == 3'b000));

   a_r2_event_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_event_i && status_o[1]) |=> status_o[0]);

   a_r3_event_ignored_off: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_event_i && !status_o[1] && !status_o[0]) |=> !status_o[0]);

   a_r4_line_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      irq_oe_o |-> (!irq_n_o && status_o[0] && !status_o[2]));

   a_r5_no_request_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[1] |-> !irq_oe_o);

   a_r8_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr_i && near) |=> (status_o[2] && !irq_oe_o));

   a_r9_bad_level_no_window: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_bad && !status_o[2]) |=> !status_o[2]);

   a_r10_rearm_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr_i && near && status_o[0] && !reg_wr_i) |=> status_o[0]);
endmodule

bind shared_irq_adapter shared_irq_adapter_chk #(.IO_AW(IO_AW)) u_chk (.*);

// File: tb/shared_irq_adapter_bench.sv
module shared_irq_adapter_bench;
   localparam int AW   = 16;
   localparam int HOLD = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    level_i = 4'd7;
   logic          dev_event_i = 1'b0;
   logic          reg_wr_i = 1'b0;
   logic [1:0]    reg_wdata_i = 2'b00;
   logic          io_wr_i = 1'b0;
   logic [AW-1:0] io_addr_i = '0;
   logic [2:0]    status_o;
   logic          irq_n_o, irq_oe_o;

   int checks = 0, failures = 0, cycles = 0;
   bit done = 0;

   int m_en = 0, m_pend = 0, m_cnt = 0;

   always #4 clk = ~clk;

   shared_irq_adapter #(.IO_AW(AW), .HOLD_CYC(HOLD)) u_shared_irq_adapter (.*);

   function automatic int exp_addr(input int lvl);
      case (lvl)
         3: return 'h2F3;  4: return 'h2F4;  5: return 'h2F5;  6: return 'h2F6;
         7: return 'h2F7;  9: return 'h2F2;  10: return 'h6F2; 11: return 'h6F3;
         12: return 'h6F4; 13: return 'h6F5; 14: return 'h6F6; 15: return 'h6F7;
         default: return -1;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // reference model, updated on every clock
   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_pend = 0; m_cnt = 0;
      end else begin
         int ea;
         bit hit;
         ea  = exp_addr(int'(level_i));
         hit = io_wr_i && (ea >= 0) && (int'(io_addr_i & 16'h07FF) == ea);
         if (dev_event_i && m_en != 0) m_pend = 1;
         else if (reg_wr_i && reg_wdata_i[1]) m_pend = 0;
         if (reg_wr_i) m_en = int'(reg_wdata_i[0]);
         if (hit) m_cnt = HOLD;
         else if (m_cnt > 0) m_cnt--;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         int drv;
         drv = (m_en != 0 && m_pend != 0 && m_cnt == 0) ? 1 : 0;
         check("R4 irq_oe_o vs model", int'(irq_oe_o), drv);
         check("R4 irq_n_o vs model", int'(irq_n_o), 1 - drv);
         check("R2/R6 status pending vs model", int'(status_o[0]), m_pend);
         check("R5 status enable vs model", int'(status_o[1]), m_en);
         check("R8 status window vs model", int'(status_o[2]), (m_cnt > 0) ? 1 : 0);
      end
      if (cycles > 20000 && !done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic tick(); @(negedge clk); endtask

   task automatic ctrl_wr(input logic [1:0] d);
      reg_wr_i = 1'b1; reg_wdata_i = d; tick(); reg_wr_i = 1'b0; reg_wdata_i = 2'b00;
   endtask

   task automatic event_pulse();
      dev_event_i = 1'b1; tick(); dev_event_i = 1'b0;
   endtask

   task automatic io_write(input int a);
      io_wr_i = 1'b1; io_addr_i = AW'(a); tick(); io_wr_i = 1'b0; io_addr_i = '0;
   endtask

   initial begin
      tick(); tick(); tick();
      // R1 reset state
      check("R1 status after reset", int'(status_o), 0);
      check("R1 oe after reset", int'(irq_oe_o), 0);
      check("R1 irq_n after reset", int'(irq_n_o), 1);
      rst_n = 1'b1;
      tick();

      // R3 event while disabled
      event_pulse();
      check("R3 event ignored while disabled", int'(status_o[0]), 0);
      check("R3 line idle", int'(irq_oe_o), 0);

      // R2 / R4 enable then event
      ctrl_wr(2'b01);
      event_pulse();
      check("R2 pending set", int'(status_o[0]), 1);
      check("R4 line driven", int'(irq_oe_o), 1);
      check("R4 line low", int'(irq_n_o), 0);

      // R7 / R8 / R10 rearm with high address bits set
      io_write('hF2F7);
      for (int i = 0; i < HOLD; i++) begin
         check("R8 window active", int'(status_o[2]), 1);
         check("R8 line released", int'(irq_oe_o), 0);
         check("R10 pending kept", int'(status_o[0]), 1);
         tick();
      end
      check("R8 window closed", int'(status_o[2]), 0);
      check("R8 line reasserted", int'(irq_oe_o), 1);

      // R9 near miss address
      io_write('h2F6);
      check("R9 wrong address no window", int'(status_o[2]), 0);

      // R11 rearm during window restarts it
      io_write('h2F7);
      tick(); tick();
      io_write('h2F7);
      for (int i = 0; i < HOLD; i++) begin
         check("R11 restarted window active", int'(status_o[2]), 1);
         tick();
      end
      check("R11 window closed after restart", int'(status_o[2]), 0);

      // R6 clear, and clear with event in the same cycle
      ctrl_wr(2'b11);
      check("R6 pending cleared", int'(status_o[0]), 0);
      check("R6 line idle after clear", int'(irq_oe_o), 0);
      event_pulse();
      reg_wr_i = 1'b1; reg_wdata_i = 2'b11; dev_event_i = 1'b1;
      tick();
      reg_wr_i = 1'b0; reg_wdata_i = 2'b00; dev_event_i = 1'b0;
      check("R6 event wins over clear", int'(status_o[0]), 1);

      // R5 disable keeps pending, stops request
      ctrl_wr(2'b00);
      check("R5 enable cleared", int'(status_o[1]), 0);
      check("R5 pending retained", int'(status_o[0]), 1);
      check("R5 no request while disabled", int'(irq_oe_o), 0);
      ctrl_wr(2'b01);
      check("R5 request returns on enable", int'(irq_oe_o), 1);

      // R7 / R9 sweep every level
      for (int l = 0; l < 16; l++) begin
         int ea;
         level_i = 4'(l);
         ea = exp_addr(l);
         io_write(ea >= 0 ? (ea | 'h3800) : 'h2F0 + l);
         check($sformatf("R7/R9 level %0d window", l), int'(status_o[2]), ea >= 0 ? 1 : 0);
         for (int i = 0; i < HOLD; i++) tick();
         io_write(ea >= 0 ? (ea ^ 'h001) : 'h6F0 + l);
         check($sformatf("R9 level %0d miss", l), int'(status_o[2]), 0);
         tick();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule